// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block is a free-running up-counter whose advance, restart and start are steered by one trigger chosen from eight candidate trigger lines. A 3-bit mode code decides what the chosen trigger does to the counter. It can be ignored, or its rising edge can restart the count. Its level can gate the count, its rising edge can start a stopped counter, or each rising edge can act as a counting clock. Encoder codes are accepted but hold the counter still.

The mode code is written through a write strobe. With preload off, a written code is in force from the next clock. With preload on, the written code is parked and moved into force by the next update pulse or the next index pulse, chosen by a source bit. A master/slave bit delays every trigger effect by one clock. This lets a chained timer, driven from the trigger output, act on the same clock as this one.

Top module: `tim_slave_ctrl`

## Requirements
- R1: While rst_n is low, count, update_evt and trig_out are 0 and the mode in force is 0.
- R2: With mode 0 in force, count rises by one on each clock where cen_in is 1 and holds otherwise.
- R3: With mode 1, 2 or 3 in force, count holds its value.
- R4: With mode 4 in force, a trigger rising edge sets count to 0 on the next clock and raises update_evt for that clock. With no edge, count rises while cen_in is 1.
- R5: With mode 5 in force, count rises on a clock only when cen_in is 1 and the trigger level is 1.
- R6: With mode 6 in force, a trigger rising edge sets a run flag without changing count. From the clock after, count rises while cen_in or the flag is 1. The flag clears whenever another mode is in force.
- R7: With mode 7 in force and cen_in at 1, count rises by one for each trigger rising edge.
- R8: The trigger is trig_in[tsel]. Bits 0 to 3 are internal triggers, bit 4 is the input-1 both-edge pulse, bits 5 and 6 are filtered inputs 1 and 2, and bit 7 is the external trigger.
- R9: A rising edge is a clock where the selected trigger is 1 and its sample from the previous clock was 0.
- R10: With msm at 1, the edge and the level used by modes 4 to 7 are those of one clock earlier.
- R11: trig_out pulses for one clock, on the clock where count takes the result of a trigger edge, in modes 4 to 7 only.
- R12: count wraps from 0xFFFF to 0 and update_evt is 1 on the clock count shows 0 after the wrap.
- R13: With pre_en at 0, a written mode is in force from the next clock. With pre_en at 1, it is in force only after a clock where update_evt (pre_src 0) or index_evt (pre_src 1) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cen_in | input | 1 | counter enable bit |
| mode_wr | input | 1 | mode write strobe |
| mode_wdata | input | 3 | mode code written |
| tsel | input | 3 | trigger select |
| trig_in | input | 8 | candidate trigger lines |
| msm | input | 1 | delay trigger effects by one clock |
| pre_en | input | 1 | mode preload enable |
| pre_src | input | 1 | preload transfer source: 0 update, 1 index |
| index_evt | input | 1 | index event pulse |
| count | output | 16 | counter value |
| update_evt | output | 1 | update event pulse |
| trig_out | output | 1 | trigger output to chained timers |

## Verification
Random runs change the mode code, trigger select, trigger line activity and enable. Reset mode is told apart from external-clock mode by whether an edge zeroes or advances the count, and gated from trigger mode by whether a falling level stops counting. Random msm and preload settings show whether trigger effects land one clock late and whether a written mode waits for its update or index pulse. Directed runs cover reset values, a trigger line change that only an unselected line sees, and the full wrap from 0xFFFF.

// File: rtl/tim_slave_ctrl.sv
module tim_slave_ctrl #(
  parameter int CW    = 16,
  parameter int NTRIG = 8,
  parameter int SW    = $clog2(NTRIG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cen_in,
  input  logic          mode_wr,
  input  logic [2:0]    mode_wdata,
  input  logic [SW-1:0] tsel,
  input  logic [NTRIG-1:0] trig_in,
  input  logic          msm,
  input  logic          pre_en,
  input  logic          pre_src,
  input  logic          index_evt,
  output logic [CW-1:0] count,
  output logic          update_evt,
  output logic          trig_out
);
  localparam logic [CW-1:0] MAXC = {CW{1'b1}};

  logic [2:0] mode_act, mode_pend;
  logic sel, sel_q, rise, rise_q, eff_rise, eff_lvl;
  logic started, tick, wrap, rst_evt, xfer;

  assign sel      = trig_in[tsel];
  assign rise     = sel & ~sel_q;
  assign eff_rise = msm ? rise_q : rise;
  assign eff_lvl  = msm ? sel_q : sel;
  assign xfer     = pre_en & (pre_src ? index_evt : update_evt);
  assign rst_evt  = (mode_act == 3'd4) & eff_rise;
  assign wrap     = tick & (count == MAXC);

  always_comb begin
    case (mode_act)
      3'd0, 3'd4: tick = cen_in;
      3'd5:       tick = cen_in & eff_lvl;
      3'd6:       tick = cen_in | started;
      3'd7:       tick = cen_in & eff_rise;
      default:    tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= 1'b0;
      rise_q     <= 1'b0;
      mode_act   <= 3'd0;
      mode_pend  <= 3'd0;
      started    <= 1'b0;
      count      <= '0;
      update_evt <= 1'b0;
      trig_out   <= 1'b0;
    end else begin
      sel_q  <= sel;
      rise_q <= rise;
      if (mode_wr) mode_pend <= mode_wdata;
      if (mode_wr && !pre_en) mode_act <= mode_wdata;
      else if (xfer)          mode_act <= mode_pend;
      started <= (mode_act == 3'd6) & (started | eff_rise);
      if (rst_evt)   count <= '0;
      else if (tick) count <= count + 1'b1;
      update_evt <= rst_evt | wrap;
      trig_out   <= mode_act[2] & eff_rise;
    end
  end

  assert_upd_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    update_evt |-> count == '0);

  assert_free_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 3'd0 && cen_in) |=> count == CW'($past(count) + 1'b1));

  assert_encoder_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act inside {3'd1, 3'd2, 3'd3}) |=> $stable(count));

  assert_gate_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 3'd5 && !cen_in) |=> $stable(count));

  assert_trig_out_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_act[2]) |=> !trig_out);

  assert_preload_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && !(pre_src ? index_evt : update_evt)) |=> $stable(mode_act));
endmodule

// File: tb/test_tim_slave_ctrl.sv
module test_tim_slave_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cen_in = 0, mode_wr = 0, msm = 0, pre_en = 0, pre_src = 0, index_evt = 0;
  logic [2:0] mode_wdata = 0, tsel = 0;
  logic [7:0] trig_in = 0;
  logic [15:0] count;
  logic update_evt, trig_out;
  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  tim_slave_ctrl i_tim_slave_ctrl (.clk, .rst_n, .cen_in, .mode_wr, .mode_wdata, .tsel,
    .trig_in, .msm, .pre_en, .pre_src, .index_evt, .count, .update_evt, .trig_out);

  // reference state, updated from the requirements at each rising edge
  logic [15:0] m_cnt = 0;
  logic [2:0] m_mode = 0, m_pend = 0;
  logic m_upd = 0, m_to = 0, m_prev = 0, m_rd = 0, m_run = 0;

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1, 3'd2, 3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic s, r, er, el, t, re;
    s  = trig_in[tsel];                 // R8 selection
    r  = s & ~m_prev;                   // R9 edge
    er = msm ? m_rd : r;                // R10 delay
    el = msm ? m_prev : s;
    case (m_mode)
      3'd0, 3'd4: t = cen_in;
      3'd5: t = cen_in & el;
      3'd6: t = cen_in | m_run;
      3'd7: t = cen_in & er;
      default: t = 1'b0;
    endcase
    re = (m_mode == 3'd4) & er;
    m_to = m_mode[2] & er;
    m_run = (m_mode == 3'd6) & (m_run | er);
    if (mode_wr && !pre_en) m_mode = mode_wdata;
    else if (pre_en && (pre_src ? index_evt : m_upd)) m_mode = m_pend;
    if (mode_wr) m_pend = mode_wdata;
    m_upd = re | (t & (m_cnt == 16'hFFFF));
    if (re) m_cnt = 0; else if (t) m_cnt = m_cnt + 1;
    m_prev = s;
    m_rd = r;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(mode_tag(m_mode), count, m_cnt);
    check(m_mode == 3'd4 ? "R4" : "R12", update_evt, m_upd);
    check("R11", trig_out, m_to);
  endtask

  task automatic write_mode(input logic [2:0] m);
    mode_wr = 1; mode_wdata = m; step(); mode_wr = 0;
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    #1;
    // R1 reset values
    check("R1", count, 0); check("R1", update_evt, 0); check("R1", trig_out, 0);
    @(negedge clk); rst_n = 1;

    // R2 free count, then hold
    cen_in = 1; repeat (5) step();
    check("R2", count, 5);
    cen_in = 0; repeat (3) step();
    check("R2", count, 5);

    // R4 reset mode through select 7 (R8), msm off
    cen_in = 1; tsel = 3'd7; write_mode(3'd4);
    repeat (3) step();
    trig_in[7] = 1; step();
    check("R4", count, 0); check("R4", update_evt, 1); check("R11", trig_out, 1);
    // R8 activity on an unselected line has no effect
    trig_in[3] = 1; step(); step();
    check("R8", count, 2); check("R8", update_evt, 0);
    trig_in = 0; step();

    // R10 delayed edge in external clock mode
    write_mode(3'd7); msm = 1; tsel = 3'd5;
    trig_in[5] = 1; step();
    check("R10", trig_out, 0);
    step();
    check("R10", trig_out, 1);
    trig_in = 0; msm = 0; step();

    // R13 preload by index
    pre_en = 1; pre_src = 1; write_mode(3'd1);
    cen_in = 1; trig_in[5] = 1; step(); trig_in[5] = 0; step();
    index_evt = 1; step(); index_evt = 0;
    begin
      logic [15:0] c0;
      c0 = count; repeat (3) step();
      check("R13", count, c0);          // encoder code now holds (R3)
    end
    pre_en = 0; write_mode(3'd0);

    // R12 full wrap
    cen_in = 1;
    while (count != 16'hFFFF) step();
    step();
    check("R12", count, 0); check("R12", update_evt, 1);

    // random phase covering R5 R6 and all modes
    repeat (20000) begin
      if ($urandom_range(99) < 4) begin
        mode_wr = 1; mode_wdata = 3'($urandom_range(7));
      end else mode_wr = 0;
      if ($urandom_range(99) < 2) tsel = 3'($urandom_range(7));
      if ($urandom_range(99) < 2) msm = ~msm;
      if ($urandom_range(99) < 2) pre_en = ~pre_en;
      if ($urandom_range(99) < 2) pre_src = ~pre_src;
      index_evt = ($urandom_range(99) < 3);
      cen_in = ($urandom_range(99) < 70);
      for (int k = 0; k < 8; k++) if ($urandom_range(99) < 25) trig_in[k] = ~trig_in[k];
      step();
    end
    mode_wr = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule